// File: doc/BRIEF.md
# Row Interleave Clock-Domain Bridge

This block joins a fast front end, clocked at LANES times the frequency of a slow back end, to that back end, which works on LANES image rows at once. A single raster-ordered stream of per-pixel cost words enters in the fast domain. The block steers each row as a whole to one of LANES lanes, rotating through the lanes one row after another. Each lane has its own dual-clock FIFO that delivers the words to the slow domain.

On the return path the slow back end produces one result per cost word on each lane. Each lane pushes its results into its own dual-clock FIFO. In the fast domain the block pulls the results out in the same row rotation and emits one stream in the original raster order.

Every data interface uses valid/ready. A transfer happens on a rising edge of the interface's clock when valid and ready are both high. The source must hold valid and data steady until the transfer. Ready on every port reflects FIFO space or the availability of the selected lane only, and never depends on the matching valid.

Top module: `row_lane_bridge`

## Requirements
- R1: While reset is applied and on its release, `out_valid` and every `lane_valid` bit are low, while `in_ready` and every `res_ready` bit are high.
- R2: Input words are counted from reset in groups of LINE_W, with each group being one row. Row number r is delivered only on lane r mod LANES, and each lane delivers its words in arrival order.
- R3: `in_ready` is high exactly when the FIFO of the lane that owns the current row has space. A word offered while `in_ready` is low is not taken, and the FIFO is never written while full.
- R4: `lane_valid[i]` is high while lane i's FIFO holds a word, and `lane_data` slice i is that oldest word. The word stays valid and unchanged until `lane_ready[i]` takes it.
- R5: `res_ready[i]` falls when lane i's result FIFO holds DEPTH entries and rises again once the fast side has drained one.
- R6: The output stream carries the results in input order: LINE_W results from lane 0, then LINE_W from lane 1, and so on round the lanes, repeating.
- R7: `out_valid` is low whenever the lane whose turn it is has no result, even if other lanes hold results, and an empty FIFO is never popped.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged into the next cycle.
- R9: With the slow side taking nothing, a lane FIFO accepts exactly DEPTH words before `in_ready` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast domain clock (LANES times the slow clock) |
| fast_rst_n | input | 1 | Fast domain asynchronous reset, active low |
| slow_clk | input | 1 | Slow domain clock |
| slow_rst_n | input | 1 | Slow domain asynchronous reset, active low |
| in_valid | input | 1 | Cost word offered (fast domain) |
| in_ready | output | 1 | Cost word can be taken |
| in_data | input | COST_W | Cost word, raster order |
| lane_valid | output | LANES | Per-lane cost word available (slow domain) |
| lane_ready | input | LANES | Per-lane cost word taken |
| lane_data | output | LANES*COST_W | Per-lane cost word, lane i at bits i*COST_W upward |
| res_valid | input | LANES | Per-lane result offered (slow domain) |
| res_ready | output | LANES | Per-lane result can be taken |
| res_data | input | LANES*DISP_W | Per-lane result, lane i at bits i*DISP_W upward |
| out_valid | output | 1 | Reinterleaved result available (fast domain) |
| out_ready | input | 1 | Result taken |
| out_data | output | DISP_W | Result, raster order |

## Verification
The assertions assume that every source keeps valid high, with data unchanged, until the transfer happens. They also assume that both resets are asserted together and released together, and that each lane's back end gives back exactly one result per cost word it takes. The bench's input driver and its model of the slow back end hold each offered word until the handshake completes. The back-end model keeps a one-entry buffer per lane and returns one result per taken word. Both resets are driven from a single sequence. The two clocks run at an exact 2:1 ratio with an offset, so no edges coincide.

// File: rtl/rlb_pkg.sv
package rlb_pkg;

  // Binary to reflected Gray code for FIFO pointers.
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Width of a lane index for a given lane count.
  function automatic int sel_width(input int lanes);
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction

endpackage

// File: rtl/rlb_afifo.sv
module rlb_afifo
  import rlb_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic         full,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         rd_en,
  output logic [W-1:0] rdata,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin, wgray, wbin_nx;
  logic [PW-1:0] rbin, rgray, rbin_nx;
  logic [PW-1:0] rg_s1, rg_s2;   // read pointer seen in write domain
  logic [PW-1:0] wg_s1, wg_s2;   // write pointer seen in read domain
  logic          do_wr, do_rd;

  // Full when the write pointer has lapped the read pointer once.
  assign full    = (wgray == {~rg_s2[PW-1:PW-2], rg_s2[PW-3:0]});
  assign empty   = (rgray == wg_s2);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign wbin_nx = wbin + PW'(1);
  assign rbin_nx = rbin + PW'(1);
  assign rdata   = mem[rbin[AW-1:0]];

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (do_wr) begin
      wbin  <= wbin_nx;
      wgray <= PW'(to_gray(32'(wbin_nx)));
    end
  end

  always_ff @(posedge wclk) begin
    if (do_wr) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (do_rd) begin
      rbin  <= rbin_nx;
      rgray <= PW'(to_gray(32'(rbin_nx)));
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      wg_s1 <= '0;
      wg_s2 <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
    end
  end
endmodule

// File: rtl/rlb_row_seq.sv
module rlb_row_seq
  import rlb_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LINE_W = 8,
  localparam int SW    = sel_width(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [SW-1:0] sel
);
  localparam int CW = $clog2(LINE_W + 1);

  logic [CW-1:0] col;

  // Column position inside the current row; lane rotates at each row end.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
      sel <= '0;
    end else if (step) begin
      if (col == CW'(LINE_W - 1)) begin
        col <= '0;
        sel <= (sel == SW'(LANES - 1)) ? '0 : sel + SW'(1);
      end else begin
        col <= col + CW'(1);
      end
    end
  end
endmodule

// File: rtl/rlb_row_demux.sv
module rlb_row_demux
  import rlb_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int W      = 16,
  parameter int LINE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_data,
  input  logic [LANES-1:0] lane_full,
  output logic [LANES-1:0] lane_wr,
  output logic [W-1:0]     lane_wdata
);
  localparam int SW = sel_width(LANES);

  logic [SW-1:0] sel;
  logic          take;

  rlb_row_seq #(.LANES(LANES), .LINE_W(LINE_W)) seq_i (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (take),
    .sel   (sel)
  );

  assign in_ready   = !lane_full[sel];
  assign take       = in_valid && in_ready;
  assign lane_wdata = in_data;

  for (genvar g = 0; g < LANES; g++) begin : g_wr
    assign lane_wr[g] = take && (sel == SW'(g));
  end
endmodule

// File: rtl/rlb_row_mux.sv
module rlb_row_mux
  import rlb_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int W      = 8,
  parameter int LINE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANES-1:0]   lane_empty,
  input  logic [LANES*W-1:0] lane_rdata,
  output logic [LANES-1:0]   lane_rd,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [W-1:0]       out_data
);
  localparam int SW = sel_width(LANES);

  logic [SW-1:0] sel;
  logic          give;
  logic [W-1:0]  word [LANES];

  rlb_row_seq #(.LANES(LANES), .LINE_W(LINE_W)) seq_i (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (give),
    .sel   (sel)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    assign word[g]    = lane_rdata[g*W +: W];
    assign lane_rd[g] = give && (sel == SW'(g));
  end

  assign out_valid = !lane_empty[sel];
  assign out_data  = word[sel];
  assign give      = out_valid && out_ready;
endmodule

// File: rtl/row_lane_bridge.sv
module row_lane_bridge #(
  parameter int LANES  = 2,
  parameter int COST_W = 16,
  parameter int DISP_W = 8,
  parameter int LINE_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                      fast_clk,
  input  logic                      fast_rst_n,
  input  logic                      slow_clk,
  input  logic                      slow_rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [COST_W-1:0]         in_data,
  output logic [LANES-1:0]          lane_valid,
  input  logic [LANES-1:0]          lane_ready,
  output logic [LANES*COST_W-1:0]   lane_data,
  input  logic [LANES-1:0]          res_valid,
  output logic [LANES-1:0]          res_ready,
  input  logic [LANES*DISP_W-1:0]   res_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [DISP_W-1:0]         out_data
);
  logic [LANES-1:0]        ing_wr, ing_full, ing_empty, ing_rd;
  logic [LANES-1:0]        egr_full, egr_empty, egr_rd;
  logic [COST_W-1:0]       cost_bus;
  logic [LANES*DISP_W-1:0] egr_rdata;

  // Fast domain: split raster stream by row.
  rlb_row_demux #(.LANES(LANES), .W(COST_W), .LINE_W(LINE_W)) demux_i (
    .clk        (fast_clk),
    .rst_n      (fast_rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .lane_full  (ing_full),
    .lane_wr    (ing_wr),
    .lane_wdata (cost_bus)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // Into the slow domain: written fast, read slow.
    rlb_afifo #(.W(COST_W), .DEPTH(DEPTH)) ing_i (
      .wclk   (fast_clk),
      .wrst_n (fast_rst_n),
      .wr_en  (ing_wr[g]),
      .wdata  (cost_bus),
      .full   (ing_full[g]),
      .rclk   (slow_clk),
      .rrst_n (slow_rst_n),
      .rd_en  (ing_rd[g]),
      .rdata  (lane_data[g*COST_W +: COST_W]),
      .empty  (ing_empty[g])
    );
    assign lane_valid[g] = !ing_empty[g];
    assign ing_rd[g]     = lane_ready[g] && !ing_empty[g];

    // Out of the slow domain: written slow, read fast.
    rlb_afifo #(.W(DISP_W), .DEPTH(DEPTH)) egr_i (
      .wclk   (slow_clk),
      .wrst_n (slow_rst_n),
      .wr_en  (res_valid[g]),
      .wdata  (res_data[g*DISP_W +: DISP_W]),
      .full   (egr_full[g]),
      .rclk   (fast_clk),
      .rrst_n (fast_rst_n),
      .rd_en  (egr_rd[g]),
      .rdata  (egr_rdata[g*DISP_W +: DISP_W]),
      .empty  (egr_empty[g])
    );
    assign res_ready[g] = !egr_full[g];
  end

  // Fast domain: rebuild raster stream in the same row rotation.
  rlb_row_mux #(.LANES(LANES), .W(DISP_W), .LINE_W(LINE_W)) mux_i (
    .clk        (fast_clk),
    .rst_n      (fast_rst_n),
    .lane_empty (egr_empty),
    .lane_rdata (egr_rdata),
    .lane_rd    (egr_rd),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data)
  );
endmodule

// File: rtl/rlb_bridge_chk.sv
module rlb_bridge_chk #(
  parameter int LANES  = 2,
  parameter int COST_W = 16,
  parameter int DISP_W = 8
) (
  input logic                    fast_clk,
  input logic                    fast_rst_n,
  input logic                    slow_clk,
  input logic                    slow_rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [COST_W-1:0]       in_data,
  input logic [LANES-1:0]        lane_valid,
  input logic [LANES-1:0]        lane_ready,
  input logic [LANES*COST_W-1:0] lane_data,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [DISP_W-1:0]       out_data,
  input logic [LANES-1:0]        ing_wr,
  input logic [LANES-1:0]        ing_full,
  input logic [LANES-1:0]        egr_rd,
  input logic [LANES-1:0]        egr_empty
);
  // R1
  reset_idle_chk: assert property (@(posedge fast_clk)
    $rose(fast_rst_n) |-> (!out_valid && in_ready));

  // R3
  no_overflow_chk: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    (ing_wr & ing_full) == '0);

  // R3
  src_hold_chk: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    (in_valid && !in_ready) |=> (in_valid && $stable(in_data)));

  // R2
  one_lane_chk: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    $onehot0(ing_wr));

  // R7
  no_underflow_chk: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    (egr_rd & egr_empty) == '0);

  // R8
  out_hold_chk: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R4
    lane_hold_chk: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
      (lane_valid[g] && !lane_ready[g]) |=>
        (lane_valid[g] && $stable(lane_data[g*COST_W +: COST_W])));
  end
endmodule

bind row_lane_bridge rlb_bridge_chk #(
  .LANES  (LANES),
  .COST_W (COST_W),
  .DISP_W (DISP_W)
) chk_i (
  .fast_clk   (fast_clk),
  .fast_rst_n (fast_rst_n),
  .slow_clk   (slow_clk),
  .slow_rst_n (slow_rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .lane_valid (lane_valid),
  .lane_ready (lane_ready),
  .lane_data  (lane_data),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .ing_wr     (ing_wr),
  .ing_full   (ing_full),
  .egr_rd     (egr_rd),
  .egr_empty  (egr_empty)
);

// File: tb/row_lane_bridge_tb.sv
module row_lane_bridge_tb_top;
  localparam int LANES  = 2;
  localparam int COST_W = 16;
  localparam int DISP_W = 8;
  localparam int LINE_W = 8;
  localparam int DEPTH  = 4;
  localparam int ROWS   = 16;
  localparam int TOTAL  = ROWS * LINE_W;

  logic fast_clk = 1'b0, slow_clk = 1'b0;
  logic fast_rst_n = 1'b0, slow_rst_n = 1'b0;
  logic                      in_valid = 1'b0;
  logic                      in_ready;
  logic [COST_W-1:0]         in_data = '0;
  logic [LANES-1:0]          lane_valid;
  logic [LANES-1:0]          lane_ready = '0;
  logic [LANES*COST_W-1:0]   lane_data;
  logic [LANES-1:0]          res_valid = '0;
  logic [LANES-1:0]          res_ready;
  logic [LANES*DISP_W-1:0]   res_data = '0;
  logic                      out_valid;
  logic                      out_ready = 1'b0;
  logic [DISP_W-1:0]         out_data;

  int checks = 0, errors = 0;
  int fcyc = 0, scyc = 0;
  int idx = 0, out_idx = 0;
  bit acc_pend = 0, in_en = 0, gap_on = 0, out_stall = 1, lane_pat = 0, done = 0;
  bit ohold = 0, saw_rfull = 0;
  logic [DISP_W-1:0] ohold_d = '0;
  logic [LANES-1:0] lane_stall = '0;
  int lk [LANES];
  bit bfull [LANES];
  logic [DISP_W-1:0] bword [LANES];
  bit lhold [LANES];
  logic [COST_W-1:0] lhold_d [LANES];

  always #4 fast_clk = ~fast_clk;   // 125 MHz
  initial begin
    #2;
    forever #8 slow_clk = ~slow_clk;  // exactly half rate, offset edges
  end

  row_lane_bridge #(
    .LANES(LANES), .COST_W(COST_W), .DISP_W(DISP_W), .LINE_W(LINE_W), .DEPTH(DEPTH)
  ) dut_i (
    .fast_clk(fast_clk), .fast_rst_n(fast_rst_n),
    .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .lane_valid(lane_valid), .lane_ready(lane_ready), .lane_data(lane_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [COST_W-1:0] word_of(input int k);
    return {8'(k / LINE_W), 8'(k % LINE_W)};
  endfunction

  function automatic logic [DISP_W-1:0] res_of(input int k);
    return {4'(k / LINE_W), 4'(k % LINE_W)};
  endfunction

  // Fast domain: input driver and output checker, both at the falling edge.
  always @(negedge fast_clk) begin
    fcyc++;
    if (fast_rst_n) begin
      if (acc_pend) begin
        idx++;
        in_valid = 1'b0;
        acc_pend = 1'b0;
      end
      if (!in_valid && in_en && idx < TOTAL && (!gap_on || (fcyc % 3) != 1)) begin
        in_valid = 1'b1;
        in_data  = word_of(idx);
      end
      acc_pend = in_valid && in_ready;

      out_ready = !out_stall && ((fcyc % 5) != 2);
      if (ohold)
        chk(out_valid && out_data == ohold_d, "R8 held output", int'(out_data), int'(ohold_d));
      if (out_valid && out_ready) begin
        // R6 R7: order across lanes
        chk(out_data == res_of(out_idx), "R6 output order", int'(out_data), int'(res_of(out_idx)));
        out_idx++;
      end
      ohold   = out_valid && !out_ready;
      ohold_d = out_data;
    end
  end

  // Slow domain: model of the per-lane back end with a one-entry buffer.
  always @(negedge slow_clk) begin
    scyc++;
    if (slow_rst_n) begin
      for (int i = 0; i < LANES; i++) begin
        bit rfire, lr, infire, stl;
        int w;
        if (!res_ready[i]) saw_rfull = 1'b1;
        if (lhold[i])
          chk(lane_valid[i] && lane_data[i*COST_W +: COST_W] == lhold_d[i],
              "R4 lane word held", int'(lane_data[i*COST_W +: COST_W]), int'(lhold_d[i]));
        rfire = bfull[i] && res_ready[i];
        res_valid[i] = bfull[i];
        res_data[i*DISP_W +: DISP_W] = bword[i];
        stl = lane_stall[i] || (lane_pat && ((scyc + i) % 4) == 0);
        lr = !stl && (!bfull[i] || rfire);
        lane_ready[i] = lr;
        infire = lane_valid[i] && lr;
        if (infire) begin
          w = ((lk[i] / LINE_W) * LANES + i) * LINE_W + (lk[i] % LINE_W);
          // R2: row r lands on lane r mod LANES, in order
          chk(lane_data[i*COST_W +: COST_W] == word_of(w), "R2 lane routing",
              int'(lane_data[i*COST_W +: COST_W]), int'(word_of(w)));
          bword[i] = {lane_data[i*COST_W + 8 +: 4], lane_data[i*COST_W +: 4]};
          lk[i]++;
        end
        bfull[i] = (bfull[i] && !rfire) || infire;
        lhold[i] = lane_valid[i] && !lr;
        lhold_d[i] = lane_data[i*COST_W +: COST_W];
      end
    end
  end

  initial begin
    for (int i = 0; i < LANES; i++) begin
      lk[i] = 0; bfull[i] = 0; bword[i] = '0; lhold[i] = 0; lhold_d[i] = '0;
    end
    repeat (10) @(negedge fast_clk);
    fast_rst_n = 1'b1;
    slow_rst_n = 1'b1;
    repeat (6) @(negedge fast_clk);
    #1;
    // R1: idle state after reset
    chk(!out_valid, "R1 out_valid idle", int'(out_valid), 0);
    chk(in_ready, "R1 in_ready idle", int'(in_ready), 1);
    chk(lane_valid == '0, "R1 lane_valid idle", int'(lane_valid), 0);
    chk(res_ready == '1, "R1 res_ready idle", int'(res_ready), (1 << LANES) - 1);

    // Phase 1: back end and output stalled, fill lane 0.
    lane_stall = '1;
    out_stall  = 1'b1;
    in_en      = 1'b1;
    repeat (60) @(negedge fast_clk);
    #1;
    chk(idx + int'(acc_pend) == DEPTH, "R9 lane capacity", idx + int'(acc_pend), DEPTH);
    chk(!in_ready, "R3 backpressure on full lane", int'(in_ready), 0);
    chk(lane_valid == 2'b01, "R2 only lane 0 loaded", int'(lane_valid), 1);
    chk(!out_valid, "R7 nothing to emit", int'(out_valid), 0);

    // Phase 2: lane 1 stalled; output drains row 0 then waits on lane 1.
    lane_stall = 2'b10;
    out_stall  = 1'b0;
    repeat (300) @(negedge fast_clk);
    #1;
    chk(out_idx == LINE_W, "R7 output waits on lane 1", out_idx, LINE_W);
    chk(!out_valid, "R7 out_valid low for empty turn", int'(out_valid), 0);
    chk(idx + int'(acc_pend) == LINE_W + DEPTH, "R3 input halted by lane 1",
        idx + int'(acc_pend), LINE_W + DEPTH);

    // Phase 3: back end runs with stalls, output blocked, result FIFOs fill.
    lane_stall = '0;
    lane_pat   = 1'b1;
    gap_on     = 1'b1;
    out_stall  = 1'b1;
    repeat (300) @(negedge fast_clk);
    #1;
    chk(saw_rfull, "R5 res_ready fell on full result FIFO", int'(saw_rfull), 1);
    chk(res_ready[1] == 1'b0, "R5 lane 1 result FIFO full", int'(res_ready[1]), 0);
    chk(out_valid, "R7 out_valid with lane 1 data", int'(out_valid), 1);
    chk(out_idx == LINE_W, "R8 nothing taken while blocked", out_idx, LINE_W);

    // Phase 4: release output with a ready pattern and run to completion.
    out_stall = 1'b0;
    for (int c = 0; c < 20000 && out_idx < TOTAL; c++) @(negedge fast_clk);
    #1;
    chk(out_idx == TOTAL, "R6 all results emitted", out_idx, TOTAL);
    chk(lk[0] == TOTAL / LANES, "R2 lane 0 word count", lk[0], TOTAL / LANES);
    chk(lk[1] == TOTAL / LANES, "R2 lane 1 word count", lk[1], TOTAL / LANES);
    chk(!out_valid, "R7 idle after drain", int'(out_valid), 0);
    chk(in_ready, "R3 ready after drain", int'(in_ready), 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge fast_clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", out_idx, TOTAL);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule